// File: doc/BRIEF.md
# Supply Window Monitor with Fault Filters

This block turns two supply comparator results into a supply-good status and a permission to drive the power switch. One input reports that the supply is above the low limit. The other reports that the supply is above the high limit. Each input first passes through a two-flop synchronizer. Each then passes through its own glitch filter, and that filter acts only on the edge that enters a fault. A dip below the low limit must last much longer than an excursion above the high limit before it counts. A return into the window is accepted at once.

The first time after reset, the gate is allowed only after the supply has stayed inside the window for a qualification period. If the supply leaves the window during that period, the period starts again from zero. Once the gate has been granted, a qualified fault removes permission in the same cycle that supply-good falls. Permission comes back as soon as the supply re-enters the window, with no new qualification period. All times are counted in clock cycles and set by parameters: `UV_FILT_CYC`, `OV_FILT_CYC` and `QUAL_CYC`.

The controller has four states:
- **IDLE**: waiting before the first grant.
- **QUAL**: counting the qualification period.
- **ON**: granted and inside the window.
- **HOLD**: granted earlier, now outside the window.

The transitions are:
- IDLE→QUAL when the supply is in the window.
- QUAL→IDLE when the supply leaves the window (this restarts the count).
- QUAL→ON when the count completes.
- ON→HOLD when the supply leaves the window.
- HOLD→ON when the supply returns to the window.

Top module: `supply_window_mon`

## Requirements
- R1: While `rst_n` is low, `supply_good_o` and `gate_en_o` are both 0.
- R2: A low level on `uv_ok_i` becomes a fault only after it has lasted `UV_FILT_CYC` consecutive cycles. `supply_good_o` then falls `UV_FILT_CYC`+2 rising edges after the input changes. A shorter low pulse has no effect on `supply_good_o`.
- R3: A high level on `ov_flt_i` becomes a fault only after it has lasted `OV_FILT_CYC` consecutive cycles. `supply_good_o` then falls `OV_FILT_CYC`+2 rising edges after the input changes. A shorter high pulse has no effect on `supply_good_o`.
- R4: Leaving a fault is not filtered. `supply_good_o` rises 3 rising edges after both inputs are back inside the window.
- R5: `supply_good_o` is 1 exactly when neither filtered fault is present.
- R6: After reset, `gate_en_o` first rises only when `supply_good_o` has been 1 for `QUAL_CYC`+1 consecutive rising edges.
- R7: `gate_en_o` is never 1 while `supply_good_o` is 0. A qualified fault drops both outputs in the same cycle.
- R8: If the supply leaves the window during qualification, the qualification count restarts from zero.
- R9: After the first grant, `gate_en_o` equals `supply_good_o` with no further delay.
- R10: Input polarity: `uv_ok_i`=1 means the supply is above the low limit, and `ov_flt_i`=1 means the supply is above the high limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv_ok_i | input | 1 | Low-limit comparator, 1 = above the low limit |
| ov_flt_i | input | 1 | High-limit comparator, 1 = above the high limit |
| supply_good_o | output | 1 | Supply is inside the window (filtered) |
| gate_en_o | output | 1 | Permission to turn on the power switch |

## Verification
Two events can land in the same cycle: the low-limit filter can qualify a fault on the very edge where the qualification count completes. The bench provokes this by starting a low dip exactly `UV_FILT_CYC`+2 edges before the expected grant. It judges the result by requiring that `gate_en_o` stays 0 in that cycle (R7). It then requires that the gate returns without a second delay as soon as the dip ends (R9). Random input streams are also compared each cycle against a model of the requirements. These streams mix pulses just shorter than and just longer than each filter length.

// File: rtl/swm_pkg.sv
package swm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_QUAL = 2'd1,
        ST_ON   = 2'd2,
        ST_HOLD = 2'd3
    } swm_state_e;
endpackage

// File: rtl/swm_sync.sv
module swm_sync #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q_o    <= RST_VAL;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/swm_fault_filter.sv
module swm_fault_filter #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bad_i,
    output logic fault_o
);
    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] run_q;

    // Fault entry waits for LEN consecutive bad samples; exit is immediate.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q   <= '0;
            fault_o <= 1'b1;
        end else if (!bad_i) begin
            run_q   <= '0;
            fault_o <= 1'b0;
        end else if (!fault_o) begin
            if (run_q == LAST) begin
                run_q   <= '0;
                fault_o <= 1'b1;
            end else begin
                run_q <= run_q + CW'(1);
            end
        end
    end

    AST_FLT_FAST_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_i |=> !fault_o);                                      // R4
    AST_FLT_RISE_NEEDS_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_o) |-> $past(bad_i));                          // R2
    AST_FLT_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= LAST);                                            // R3
endmodule

// File: rtl/supply_window_mon.sv
module supply_window_mon
    import swm_pkg::*;
#(
    parameter int UV_FILT_CYC = 600,
    parameter int OV_FILT_CYC = 5,
    parameter int QUAL_CYC    = 150000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic uv_ok_i,
    input  logic ov_flt_i,
    output logic supply_good_o,
    output logic gate_en_o
);
    localparam int QW = (QUAL_CYC > 1) ? $clog2(QUAL_CYC) : 1;
    localparam logic [QW-1:0] QLAST = QW'(QUAL_CYC - 1);

    logic uv_ok_s, ov_flt_s;
    logic uv_fault, ov_fault;
    logic in_win;

    swm_state_e state_q, state_d;
    logic [QW-1:0] qcnt_q, qcnt_d;

    swm_sync #(.RST_VAL(1'b0)) u_uv_sync (
        .clk(clk), .rst_n(rst_n), .d_i(uv_ok_i), .q_o(uv_ok_s));
    swm_sync #(.RST_VAL(1'b0)) u_ov_sync (
        .clk(clk), .rst_n(rst_n), .d_i(ov_flt_i), .q_o(ov_flt_s));

    swm_fault_filter #(.LEN(UV_FILT_CYC)) u_uv_filt (
        .clk(clk), .rst_n(rst_n), .bad_i(~uv_ok_s), .fault_o(uv_fault));
    swm_fault_filter #(.LEN(OV_FILT_CYC)) u_ov_filt (
        .clk(clk), .rst_n(rst_n), .bad_i(ov_flt_s), .fault_o(ov_fault));

    assign in_win = ~uv_fault & ~ov_fault;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        qcnt_d  = '0;
        unique case (state_q)
            ST_IDLE: if (in_win) state_d = ST_QUAL;
            ST_QUAL: begin
                if (!in_win) begin
                    state_d = ST_IDLE;
                end else if (qcnt_q == QLAST) begin
                    state_d = ST_ON;
                end else begin
                    qcnt_d = qcnt_q + QW'(1);
                end
            end
            ST_ON:   if (!in_win) state_d = ST_HOLD;
            ST_HOLD: if (in_win)  state_d = ST_ON;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            qcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            qcnt_q  <= qcnt_d;
        end
    end

    // Outputs
    always_comb begin
        supply_good_o = in_win;
        gate_en_o     = in_win & ((state_q == ST_ON) | (state_q == ST_HOLD));
    end

    AST_GATE_NEEDS_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        gate_en_o |-> supply_good_o);                              // R7
    AST_NO_GATE_BEFORE_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE || state_q == ST_QUAL) |-> !gate_en_o); // R6
    AST_QUAL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_QUAL && !in_win) |=> (state_q == ST_IDLE && qcnt_q == '0)); // R8
    AST_QCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        qcnt_q <= QLAST);                                          // R6
    AST_GRANT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ON || state_q == ST_HOLD) |=> (state_q == ST_ON || state_q == ST_HOLD)); // R9
endmodule

// File: tb/supply_window_mon_tb.sv
module supply_window_mon_tb;
    localparam int CLK_PERIOD = 10;
    localparam int UVL  = 20;
    localparam int OVL  = 4;
    localparam int QUAL = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic uv_ok = 1'b1;
    logic ov_flt = 1'b0;
    logic sg, gate;

    int total = 0;
    int bad = 0;
    bit chk_en = 1'b0;
    bit finished = 1'b0;

    supply_window_mon #(.UV_FILT_CYC(UVL), .OV_FILT_CYC(OVL), .QUAL_CYC(QUAL)) u_dut (
        .clk(clk), .rst_n(rst_n), .uv_ok_i(uv_ok), .ov_flt_i(ov_flt),
        .supply_good_o(sg), .gate_en_o(gate));

    always #(CLK_PERIOD/2) clk = ~clk;

    // Requirement model
    logic m_uv1, m_uv2, m_ov1, m_ov2, m_uvf, m_ovf, m_por;
    int m_uvrun, m_ovrun, m_winrun;

    function automatic logic filt_next(logic bad_in, logic f_prev, int run, int len);
        return bad_in && (f_prev || run >= len);
    endfunction

    function automatic logic exp_sg();
        return !m_uvf && !m_ovf;
    endfunction

    function automatic logic exp_gate();
        return m_por && exp_sg();
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_uv1 = 0; m_uv2 = 0; m_ov1 = 0; m_ov2 = 0;
            m_uvf = 1; m_ovf = 1; m_por = 0;
            m_uvrun = 0; m_ovrun = 0; m_winrun = 0;
        end else begin
            if (!m_por) begin
                m_winrun = exp_sg() ? m_winrun + 1 : 0;
                if (m_winrun >= QUAL + 1) m_por = 1;
            end
            m_uvrun = !m_uv2 ? m_uvrun + 1 : 0;
            m_uvf   = filt_next(!m_uv2, m_uvf, m_uvrun, UVL);
            m_ovrun = m_ov2 ? m_ovrun + 1 : 0;
            m_ovf   = filt_next(m_ov2, m_ovf, m_ovrun, OVL);
            m_uv2 = m_uv1; m_uv1 = uv_ok;
            m_ov2 = m_ov1; m_ov1 = ov_flt;
        end
    end

    task automatic chk(string req, string what, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_en && rst_n) begin
            chk("R5", "supply_good vs model", sg, exp_sg());
            chk("R9", "gate vs model", gate, exp_gate());
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        chk_en = 1'b0;
        rst_n = 1'b0;
        step(4);
        chk("R1", "supply_good in reset", sg, 1'b0);
        chk("R1", "gate in reset", gate, 1'b0);
        rst_n = 1'b1;
        chk_en = 1'b1;
    endtask

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h1234_ABCD);
        uv_ok = 1'b1; ov_flt = 1'b0;
        step(1);
        do_reset();

        // First grant after qualification
        step(3);
        chk("R10", "supply_good with inputs in window", sg, 1'b1);
        step(QUAL);
        chk("R6", "gate one cycle before qualification end", gate, 1'b0);
        step(1);
        chk("R6", "gate at qualification end", gate, 1'b1);

        // Short high-limit pulse is ignored
        ov_flt = 1'b1; step(OVL - 1); ov_flt = 1'b0;
        for (int i = 0; i < OVL + 4; i++) begin
            chk("R3", "short high pulse ignored", sg, 1'b1);
            step(1);
        end
        // Short low dip is ignored
        uv_ok = 1'b0; step(UVL - 1); uv_ok = 1'b1;
        for (int i = 0; i < UVL + 4; i++) begin
            chk("R2", "short low dip ignored", sg, 1'b1);
            step(1);
        end

        // Qualified low fault and immediate recovery
        uv_ok = 1'b0;
        step(UVL + 1);
        chk("R2", "supply_good before low filter ends", sg, 1'b1);
        chk("R7", "gate before low filter ends", gate, 1'b1);
        step(1);
        chk("R2", "supply_good after low filter", sg, 1'b0);
        chk("R7", "gate drops with supply_good", gate, 1'b0);
        uv_ok = 1'b1;
        step(2);
        chk("R4", "no early recovery", sg, 1'b0);
        step(1);
        chk("R4", "recovery unfiltered", sg, 1'b1);
        chk("R9", "gate returns without delay", gate, 1'b1);

        // Qualified high fault
        ov_flt = 1'b1;
        step(OVL + 1);
        chk("R3", "supply_good before high filter ends", sg, 1'b1);
        step(1);
        chk("R3", "supply_good after high filter", sg, 1'b0);
        chk("R7", "gate off on high fault", gate, 1'b0);
        ov_flt = 1'b0;
        step(3);
        chk("R4", "recovery from high fault", sg, 1'b1);

        // Qualification restart
        do_reset();
        step(3 + QUAL / 2);
        uv_ok = 1'b0; step(UVL + 5); uv_ok = 1'b1;
        step(QUAL + 3);
        chk("R8", "gate still off, count restarted", gate, 1'b0);
        step(1);
        chk("R8", "gate after full restarted count", gate, 1'b1);

        // Fault qualifies on the same edge as qualification completes
        do_reset();
        step(QUAL + 2 - UVL);
        uv_ok = 1'b0;
        step(UVL + 1);
        chk("R6", "gate off one edge before coincidence", gate, 1'b0);
        chk("R2", "supply_good still good", sg, 1'b1);
        step(1);
        chk("R7", "gate held off on coinciding fault", gate, 1'b0);
        chk("R7", "supply_good off on coinciding fault", sg, 1'b0);
        uv_ok = 1'b1;
        step(3);
        chk("R9", "gate returns after coinciding fault", gate, 1'b1);

        // Random streams checked against the model each cycle
        for (int seg = 0; seg < 1500; seg++) begin
            int len;
            if ($urandom_range(0, 1) == 0) len = $urandom_range(1, OVL + 2);
            else len = $urandom_range(UVL - 2, UVL + 4);
            uv_ok  = ($urandom_range(0, 2) != 0);
            ov_flt = ($urandom_range(0, 3) == 0);
            step(len);
            if (seg % 500 == 250) do_reset();
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule